// File: doc/BRIEF.md
# Translation Cache Invalidation Matcher

This block keeps a small, fully associative cache of address-translation entries. Every entry records whether it is live, its stage (first or second), whether it is a leaf or a pointer to a lower table level, and whether it is global. It also records the host/VM context flag, the process and guest context tags, a page number and a page-span mask. Once per cycle it takes one normalized invalidation request. All entries that the request selects are cleared at the next rising clock edge.

Selection depends on the request kind. A first-stage request walks the four combinations of VM-context-valid and process-context-valid. A second-stage request is scoped only by guest context. A non-leaf flag extends an address-specific request to every table level. An optional range flag widens the target address into a naturally aligned, power-of-two block of pages.

A fill port writes one entry per cycle for loading the cache. A lookup port reports, in the same cycle, the lowest-numbered live leaf entry that translates a given page in a given context. The live bit of every entry is brought out so that the effect of each invalidation can be observed.

Top module: `tlbinv_cache`

## Requirements
- R1: While reset is asserted, and after it is released, every entry is invalid: `entry_valid_o` is all zero and `lkp_hit_o` is 0.
- R2: A fill writes entry `fill_idx_i` at the next rising edge. The lookup is combinational. It hits only live leaf entries whose stage matches (0 = first stage, 1 = second stage). A second-stage entry must also match the guest tag. A first-stage entry must match the host/VM flag, must match the guest tag when the flag is 1, and must match the process tag unless the entry is global. The page must equal the entry's page number outside the entry mask. The lowest matching index wins.
- R3: A first-stage request (`inv_gstage_i`=0) with VM flag 0 and process-valid 0 clears the selected host first-stage entries for every process tag, global ones included. VM entries and second-stage entries are left as they are.
- R4: A first-stage request with VM flag 0 and process-valid 1 clears only non-global host first-stage entries whose process tag equals `inv_pscid_i`.
- R5: A first-stage request with VM flag 1 and process-valid 0 clears VM first-stage entries whose guest tag equals `inv_gscid_i`, global ones included.
- R6: A first-stage request with VM flag 1 and process-valid 1 clears only non-global VM first-stage entries that match both tags.
- R7: A second-stage request (`inv_gstage_i`=1) with VM flag 1 clears second-stage entries whose guest tag matches. With VM flag 0 it clears every second-stage entry, and the address-valid, non-leaf and range flags are ignored.
- R8: An address-specific request with non-leaf flag 0 clears only leaf entries. With non-leaf flag 1 it clears entries at every level.
- R9: With address-valid 0, all entries of the selected stage and context are cleared at every level, and the address and range flag are ignored.
- R10: With address-valid and range both 1, let X be the position of the lowest 0 bit of `inv_addr_i`. The request then covers the aligned block of 2^(X+1) pages that contains the address. An address whose only 0 bit is its top bit covers the whole space.
- R11: An entry is covered when its page number equals the request page under the union of the entry span mask and the request range mask. A superpage entry is therefore hit by any page inside it.
- R12: A lookup in the same cycle as an invalidation sees the contents from before the invalidation. A fill in the same cycle as an invalidation is written after the clear, so the filled entry stays live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| inv_valid_i | input | 1 | Invalidation request present this cycle |
| inv_gstage_i | input | 1 | 0 = first-stage request, 1 = second-stage request |
| inv_av_i | input | 1 | Address-valid flag |
| inv_nl_i | input | 1 | Non-leaf flag: clear every table level |
| inv_gv_i | input | 1 | Guest-context-valid / VM flag |
| inv_pscv_i | input | 1 | Process-context-valid flag |
| inv_range_i | input | 1 | Range flag: address carries a block size |
| inv_pscid_i | input | PSCID_W | Process context tag |
| inv_gscid_i | input | GSCID_W | Guest context tag |
| inv_addr_i | input | VPN_W | Target page number (4 KiB units) |
| fill_valid_i | input | 1 | Write an entry this cycle |
| fill_idx_i | input | IDX_W | Entry slot to write |
| fill_gstage_i | input | 1 | Stage of filled entry |
| fill_leaf_i | input | 1 | Filled entry is a leaf |
| fill_global_i | input | 1 | Filled entry is global |
| fill_gv_i | input | 1 | Filled entry belongs to a VM context |
| fill_pscid_i | input | PSCID_W | Process tag of filled entry |
| fill_gscid_i | input | GSCID_W | Guest tag of filled entry |
| fill_vpn_i | input | VPN_W | Page number of filled entry |
| fill_mask_i | input | VPN_W | Span mask (low ones) of filled entry |
| lkp_gstage_i | input | 1 | Stage to look up |
| lkp_gv_i | input | 1 | Lookup in VM context |
| lkp_pscid_i | input | PSCID_W | Lookup process tag |
| lkp_gscid_i | input | GSCID_W | Lookup guest tag |
| lkp_vpn_i | input | VPN_W | Lookup page number |
| lkp_hit_o | output | 1 | A live leaf entry translates the page |
| lkp_idx_o | output | IDX_W | Lowest matching entry index |
| entry_valid_o | output | ENTRIES | Live bit of each entry |

## Verification
The lookup result depends only on the stored state and the lookup inputs. The bench therefore reads it one time unit after it drives the inputs on a falling edge, and before the next rising edge. An invalidation or fill takes effect on `entry_valid_o` exactly one rising edge after the request, so the bench checks it on the falling edge that follows that edge. The same-cycle test samples the lookup while the invalidation is pending and then samples the live vector after the edge. This separates the pre-clear view from the post-fill result.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

    typedef enum logic {
        STAGE_FIRST  = 1'b0,
        STAGE_SECOND = 1'b1
    } stage_e;

    // Request after operand-ignore rules have been applied.
    typedef struct packed {
        logic gstage;
        logic addr_spec;
        logic all_levels;
        logic gv;
        logic pscv;
    } req_flags_t;

endpackage

// File: rtl/tlbinv_req_decode.sv
module tlbinv_req_decode
    import tlbinv_pkg::*;
#(
    parameter int VPN_W = 20
) (
    input  logic             gstage_i,
    input  logic             av_i,
    input  logic             nl_i,
    input  logic             gv_i,
    input  logic             pscv_i,
    input  logic             range_i,
    input  logic [VPN_W-1:0] addr_i,
    output req_flags_t       flags_o,
    output logic [VPN_W-1:0] rmask_o
);

    logic addr_spec;

    always_comb begin
        if (gstage_i == STAGE_SECOND) begin
            // guest scope off => whole second stage, address ignored
            addr_spec    = gv_i & av_i;
            flags_o.pscv = 1'b0;
        end else begin
            addr_spec    = av_i;
            flags_o.pscv = pscv_i;
        end
        flags_o.gstage     = gstage_i;
        flags_o.gv         = gv_i;
        flags_o.addr_spec  = addr_spec;
        flags_o.all_levels = ~addr_spec | nl_i;
    end

    // trailing ones plus the first zero give the block mask
    always_comb begin
        if (addr_spec && range_i) begin
            rmask_o = addr_i ^ (addr_i + VPN_W'(1));
        end else begin
            rmask_o = '0;
        end
    end

endmodule

// File: rtl/tlbinv_entry_match.sv
module tlbinv_entry_match
    import tlbinv_pkg::*;
#(
    parameter int VPN_W   = 20,
    parameter int PSCID_W = 20,
    parameter int GSCID_W = 16
) (
    input  logic               e_valid_i,
    input  logic               e_gstage_i,
    input  logic               e_leaf_i,
    input  logic               e_global_i,
    input  logic               e_gv_i,
    input  logic [PSCID_W-1:0] e_pscid_i,
    input  logic [GSCID_W-1:0] e_gscid_i,
    input  logic [VPN_W-1:0]   e_vpn_i,
    input  logic [VPN_W-1:0]   e_mask_i,
    input  req_flags_t         rq_i,
    input  logic [PSCID_W-1:0] rq_pscid_i,
    input  logic [GSCID_W-1:0] rq_gscid_i,
    input  logic [VPN_W-1:0]   rq_addr_i,
    input  logic [VPN_W-1:0]   rq_rmask_i,
    input  logic               lk_gstage_i,
    input  logic               lk_gv_i,
    input  logic [PSCID_W-1:0] lk_pscid_i,
    input  logic [GSCID_W-1:0] lk_gscid_i,
    input  logic [VPN_W-1:0]   lk_vpn_i,
    output logic               kill_o,
    output logic               hit_o
);

    logic stage_ok, ctx_ok, addr_ok, level_ok;
    logic lk_ctx_ok, lk_addr_ok;

    always_comb begin
        if (rq_i.gstage == STAGE_SECOND) begin
            stage_ok = (e_gstage_i == STAGE_SECOND);
            ctx_ok   = ~rq_i.gv | (e_gscid_i == rq_gscid_i);
        end else begin
            stage_ok = (e_gstage_i == STAGE_FIRST);
            ctx_ok   = (e_gv_i == rq_i.gv)
                     & (~rq_i.gv | (e_gscid_i == rq_gscid_i))
                     & (~rq_i.pscv | ((e_pscid_i == rq_pscid_i) & ~e_global_i));
        end
        addr_ok  = ~rq_i.addr_spec
                 | (((e_vpn_i ^ rq_addr_i) & ~(e_mask_i | rq_rmask_i)) == '0);
        level_ok = rq_i.all_levels | e_leaf_i;
        kill_o   = e_valid_i & stage_ok & ctx_ok & addr_ok & level_ok;
    end

    always_comb begin
        if (e_gstage_i == STAGE_SECOND) begin
            lk_ctx_ok = (e_gscid_i == lk_gscid_i);
        end else begin
            lk_ctx_ok = (e_gv_i == lk_gv_i)
                      & (~lk_gv_i | (e_gscid_i == lk_gscid_i))
                      & (e_global_i | (e_pscid_i == lk_pscid_i));
        end
        lk_addr_ok = (((e_vpn_i ^ lk_vpn_i) & ~e_mask_i) == '0);
        hit_o      = e_valid_i & e_leaf_i & (e_gstage_i == lk_gstage_i)
                   & lk_ctx_ok & lk_addr_ok;
    end

endmodule

// File: rtl/tlbinv_prio.sv
module tlbinv_prio #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlbinv_cache.sv
module tlbinv_cache
    import tlbinv_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PSCID_W = 20,
    parameter int GSCID_W = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               inv_valid_i,
    input  logic               inv_gstage_i,
    input  logic               inv_av_i,
    input  logic               inv_nl_i,
    input  logic               inv_gv_i,
    input  logic               inv_pscv_i,
    input  logic               inv_range_i,
    input  logic [PSCID_W-1:0] inv_pscid_i,
    input  logic [GSCID_W-1:0] inv_gscid_i,
    input  logic [VPN_W-1:0]   inv_addr_i,
    input  logic               fill_valid_i,
    input  logic [IDX_W-1:0]   fill_idx_i,
    input  logic               fill_gstage_i,
    input  logic               fill_leaf_i,
    input  logic               fill_global_i,
    input  logic               fill_gv_i,
    input  logic [PSCID_W-1:0] fill_pscid_i,
    input  logic [GSCID_W-1:0] fill_gscid_i,
    input  logic [VPN_W-1:0]   fill_vpn_i,
    input  logic [VPN_W-1:0]   fill_mask_i,
    input  logic               lkp_gstage_i,
    input  logic               lkp_gv_i,
    input  logic [PSCID_W-1:0] lkp_pscid_i,
    input  logic [GSCID_W-1:0] lkp_gscid_i,
    input  logic [VPN_W-1:0]   lkp_vpn_i,
    output logic               lkp_hit_o,
    output logic [IDX_W-1:0]   lkp_idx_o,
    output logic [ENTRIES-1:0] entry_valid_o
);

    typedef struct packed {
        logic               valid;
        logic               gstage;
        logic               leaf;
        logic               glob;
        logic               gv;
        logic [PSCID_W-1:0] pscid;
        logic [GSCID_W-1:0] gscid;
        logic [VPN_W-1:0]   vpn;
        logic [VPN_W-1:0]   mask;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
    } state_t;

    state_t             st_d, st_q;
    req_flags_t         rq_flags;
    logic [VPN_W-1:0]   rq_rmask;
    logic [ENTRIES-1:0] kill;
    logic [ENTRIES-1:0] lk_hits;
    logic [ENTRIES-1:0] leaf_q;

    tlbinv_req_decode #(
        .VPN_W (VPN_W)
    ) u_decode (
        .gstage_i (inv_gstage_i),
        .av_i     (inv_av_i),
        .nl_i     (inv_nl_i),
        .gv_i     (inv_gv_i),
        .pscv_i   (inv_pscv_i),
        .range_i  (inv_range_i),
        .addr_i   (inv_addr_i),
        .flags_o  (rq_flags),
        .rmask_o  (rq_rmask)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlbinv_entry_match #(
            .VPN_W   (VPN_W),
            .PSCID_W (PSCID_W),
            .GSCID_W (GSCID_W)
        ) u_match (
            .e_valid_i   (st_q.ent[g].valid),
            .e_gstage_i  (st_q.ent[g].gstage),
            .e_leaf_i    (st_q.ent[g].leaf),
            .e_global_i  (st_q.ent[g].glob),
            .e_gv_i      (st_q.ent[g].gv),
            .e_pscid_i   (st_q.ent[g].pscid),
            .e_gscid_i   (st_q.ent[g].gscid),
            .e_vpn_i     (st_q.ent[g].vpn),
            .e_mask_i    (st_q.ent[g].mask),
            .rq_i        (rq_flags),
            .rq_pscid_i  (inv_pscid_i),
            .rq_gscid_i  (inv_gscid_i),
            .rq_addr_i   (inv_addr_i),
            .rq_rmask_i  (rq_rmask),
            .lk_gstage_i (lkp_gstage_i),
            .lk_gv_i     (lkp_gv_i),
            .lk_pscid_i  (lkp_pscid_i),
            .lk_gscid_i  (lkp_gscid_i),
            .lk_vpn_i    (lkp_vpn_i),
            .kill_o      (kill[g]),
            .hit_o       (lk_hits[g])
        );

        assign entry_valid_o[g] = st_q.ent[g].valid;
        assign leaf_q[g]        = st_q.ent[g].leaf;

        AST_CLEAR_APPLIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (inv_valid_i && kill[g] && !(fill_valid_i && fill_idx_i == IDX_W'(g)))
            |=> !entry_valid_o[g]); // R3

        AST_LEAF_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (inv_valid_i && rq_flags.addr_spec && !rq_flags.all_levels
             && entry_valid_o[g] && !leaf_q[g])
            |=> entry_valid_o[g]); // R8

        AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(entry_valid_o[g])
            |-> $past(fill_valid_i && fill_idx_i == IDX_W'(g))); // R2
    end

    tlbinv_prio #(
        .N     (ENTRIES),
        .IDX_W (IDX_W)
    ) u_prio (
        .req_i (lk_hits),
        .hit_o (lkp_hit_o),
        .idx_o (lkp_idx_o)
    );

    always_comb begin
        st_d = st_q;
        if (inv_valid_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (kill[i]) begin
                    st_d.ent[i].valid = 1'b0;
                end
            end
        end
        // fill lands after the clear
        if (fill_valid_i && (int'(fill_idx_i) < ENTRIES)) begin
            st_d.ent[fill_idx_i].valid  = 1'b1;
            st_d.ent[fill_idx_i].gstage = fill_gstage_i;
            st_d.ent[fill_idx_i].leaf   = fill_leaf_i;
            st_d.ent[fill_idx_i].glob   = fill_global_i;
            st_d.ent[fill_idx_i].gv     = fill_gv_i;
            st_d.ent[fill_idx_i].pscid  = fill_pscid_i;
            st_d.ent[fill_idx_i].gscid  = fill_gscid_i;
            st_d.ent[fill_idx_i].vpn    = fill_vpn_i;
            st_d.ent[fill_idx_i].mask   = fill_mask_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_FILL_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_valid_i |=> entry_valid_o[$past(fill_idx_i)]); // R12

    AST_HIT_IS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lkp_hit_o |-> entry_valid_o[lkp_idx_o]); // R2

endmodule

// File: tb/tlbinv_cache_tb.sv
`timescale 1ns/1ps
module tlbinv_cache_tb;

    localparam int ENTRIES = 8;
    localparam int VPN_W   = 20;
    localparam int PSCID_W = 20;
    localparam int GSCID_W = 16;
    localparam int IDX_W   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic               inv_valid, inv_gstage, inv_av, inv_nl, inv_gv, inv_pscv, inv_range;
    logic [PSCID_W-1:0] inv_pscid;
    logic [GSCID_W-1:0] inv_gscid;
    logic [VPN_W-1:0]   inv_addr;
    logic               fill_valid, fill_gstage, fill_leaf, fill_global, fill_gv;
    logic [IDX_W-1:0]   fill_idx;
    logic [PSCID_W-1:0] fill_pscid;
    logic [GSCID_W-1:0] fill_gscid;
    logic [VPN_W-1:0]   fill_vpn, fill_mask;
    logic               lkp_gstage, lkp_gv;
    logic [PSCID_W-1:0] lkp_pscid;
    logic [GSCID_W-1:0] lkp_gscid;
    logic [VPN_W-1:0]   lkp_vpn;
    logic               lkp_hit;
    logic [IDX_W-1:0]   lkp_idx;
    logic [ENTRIES-1:0] valid_vec;

    tlbinv_cache #(
        .ENTRIES (ENTRIES), .VPN_W (VPN_W), .PSCID_W (PSCID_W), .GSCID_W (GSCID_W)
    ) u_dut (
        .clk_i (clk), .rst_ni (rst_n),
        .inv_valid_i (inv_valid), .inv_gstage_i (inv_gstage), .inv_av_i (inv_av),
        .inv_nl_i (inv_nl), .inv_gv_i (inv_gv), .inv_pscv_i (inv_pscv),
        .inv_range_i (inv_range), .inv_pscid_i (inv_pscid), .inv_gscid_i (inv_gscid),
        .inv_addr_i (inv_addr),
        .fill_valid_i (fill_valid), .fill_idx_i (fill_idx), .fill_gstage_i (fill_gstage),
        .fill_leaf_i (fill_leaf), .fill_global_i (fill_global), .fill_gv_i (fill_gv),
        .fill_pscid_i (fill_pscid), .fill_gscid_i (fill_gscid), .fill_vpn_i (fill_vpn),
        .fill_mask_i (fill_mask),
        .lkp_gstage_i (lkp_gstage), .lkp_gv_i (lkp_gv), .lkp_pscid_i (lkp_pscid),
        .lkp_gscid_i (lkp_gscid), .lkp_vpn_i (lkp_vpn),
        .lkp_hit_o (lkp_hit), .lkp_idx_o (lkp_idx), .entry_valid_o (valid_vec)
    );

    typedef struct packed {
        logic               gst;
        logic               av;
        logic               nl;
        logic               gv;
        logic               pscv;
        logic               rng;
        logic [PSCID_W-1:0] pscid;
        logic [GSCID_W-1:0] gscid;
        logic [VPN_W-1:0]   addr;
        logic [7:0]         exp;
    } vec_t;

    // Standard load: 0 host p1 leaf @100, 1 host p2 leaf @100, 2 host global leaf @100,
    // 3 host p1 non-leaf span 000-1FF, 4 VM g5 p1 global leaf @100, 5 VM g6 p1 leaf @100,
    // 6 second g5 leaf @100, 7 second g5 non-leaf span 000-1FF. Result: live bits after one request.
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 20'd0, 16'd0, 20'h00100, 8'hF8}, // R3 R8 leaf only
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 20'd0, 16'd0, 20'h00100, 8'hF0}, // R3 R8 all levels
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 20'd1, 16'd0, 20'h00100, 8'hF6}, // R4
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 20'd3, 16'd0, 20'h00100, 8'hFF}, // R4 global kept
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 20'd0, 16'd5, 20'h00100, 8'hEF}, // R5
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0, 20'd1, 16'd5, 20'h00100, 8'hFF}, // R6 global kept
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 20'd1, 16'd6, 20'h00100, 8'hDF}, // R6
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 20'd0, 16'd5, 20'h00100, 8'hBF}, // R7 R8
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 20'd0, 16'd5, 20'h00100, 8'h3F}, // R7
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 20'd0, 16'd0, 20'h00555, 8'h3F}, // R7 no guest scope
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 20'd0, 16'd5, 20'h00555, 8'h3F}, // R9
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 20'd0, 16'd0, 20'h00555, 8'hF0}, // R9 range ignored
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 20'd1, 16'd0, 20'h00000, 8'hF6}, // R9
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 20'd0, 16'd0, 20'h00200, 8'hFF}, // R11 miss
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 20'd0, 16'd0, 20'h000FF, 8'hF0}, // R10 block 000-1FF
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 20'd0, 16'd0, 20'h000FF, 8'hF8}, // R10 R8
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 20'd0, 16'd0, 20'h7FFFF, 8'hF0}, // R10 whole space
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 20'd0, 16'd0, 20'h7FFFF, 8'hFF}, // R10 no range
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 20'd0, 16'd0, 20'h00101, 8'hF8}, // R10 block 100-103
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 20'd0, 16'd0, 20'h00101, 8'hFF}, // R10 single page
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 20'd0, 16'd5, 20'h000FF, 8'h3F}, // R10 R7
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 20'd0, 16'd0, 20'h001F0, 8'hF7}  // R11 superpage
    };

    int checks = 0;
    int errors = 0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        inv_valid = 0; inv_gstage = 0; inv_av = 0; inv_nl = 0; inv_gv = 0;
        inv_pscv = 0; inv_range = 0; inv_pscid = '0; inv_gscid = '0; inv_addr = '0;
        fill_valid = 0; fill_idx = '0; fill_gstage = 0; fill_leaf = 0; fill_global = 0;
        fill_gv = 0; fill_pscid = '0; fill_gscid = '0; fill_vpn = '0; fill_mask = '0;
        lkp_gstage = 0; lkp_gv = 0; lkp_pscid = '0; lkp_gscid = '0; lkp_vpn = '0;
    endtask

    task automatic set_fill(input int idx, input logic gst, input logic leaf,
                            input logic glob, input logic gv, input int pscid,
                            input int gscid, input int vpn, input int mask);
        fill_valid  = 1'b1;
        fill_idx    = IDX_W'(idx);
        fill_gstage = gst;
        fill_leaf   = leaf;
        fill_global = glob;
        fill_gv     = gv;
        fill_pscid  = PSCID_W'(pscid);
        fill_gscid  = GSCID_W'(gscid);
        fill_vpn    = VPN_W'(vpn);
        fill_mask   = VPN_W'(mask);
    endtask

    task automatic do_fill(input int idx, input logic gst, input logic leaf,
                           input logic glob, input logic gv, input int pscid,
                           input int gscid, input int vpn, input int mask);
        set_fill(idx, gst, leaf, glob, gv, pscid, gscid, vpn, mask);
        tick();
        fill_valid = 1'b0;
    endtask

    task automatic load_all();
        do_fill(0, 0, 1, 0, 0, 1, 0, 'h100, 0);
        do_fill(1, 0, 1, 0, 0, 2, 0, 'h100, 0);
        do_fill(2, 0, 1, 1, 0, 3, 0, 'h100, 0);
        do_fill(3, 0, 0, 0, 0, 1, 0, 'h000, 'h1FF);
        do_fill(4, 0, 1, 1, 1, 1, 5, 'h100, 0);
        do_fill(5, 0, 1, 0, 1, 1, 6, 'h100, 0);
        do_fill(6, 1, 1, 0, 1, 0, 5, 'h100, 0);
        do_fill(7, 1, 0, 0, 1, 0, 5, 'h000, 'h1FF);
    endtask

    task automatic set_inv(input vec_t v);
        inv_valid = 1'b1; inv_gstage = v.gst; inv_av = v.av; inv_nl = v.nl;
        inv_gv = v.gv; inv_pscv = v.pscv; inv_range = v.rng;
        inv_pscid = v.pscid; inv_gscid = v.gscid; inv_addr = v.addr;
    endtask

    task automatic lookup(input logic gst, input logic gv, input int pscid,
                          input int gscid, input int vpn);
        lkp_gstage = gst; lkp_gv = gv; lkp_pscid = PSCID_W'(pscid);
        lkp_gscid = GSCID_W'(gscid); lkp_vpn = VPN_W'(vpn);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog R1 actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        vec_t v;
        idle_inputs();
        @(negedge clk);
        tick(); tick();
        chk(32'(valid_vec), 0, "R1 live bits in reset");
        rst_n = 1'b1;
        tick();
        lookup(0, 0, 1, 0, 'h100);
        chk(32'(valid_vec), 0, "R1 live bits after reset");
        chk(32'(lkp_hit), 0, "R1 no hit after reset");

        // table walk
        for (int k = 0; k < NV; k++) begin
            v = VECS[k];
            load_all();
            chk(32'(valid_vec), 32'hFF, $sformatf("R2 load before vector %0d", k));
            set_inv(v);
            tick();
            inv_valid = 1'b0;
            chk(32'(valid_vec), 32'(v.exp), $sformatf("vector %0d (R3-family) live bits", k));
        end

        // lookup behaviour, R2
        load_all();
        lookup(0, 0, 2, 0, 'h100);
        chk({31'd0, lkp_hit}, 1, "R2 host p2 hit");
        chk(32'(lkp_idx), 1, "R2 host p2 index");
        lookup(0, 0, 9, 0, 'h100);
        chk(32'(lkp_idx), 2, "R2 global entry index");
        lookup(0, 0, 1, 0, 'h100);
        chk(32'(lkp_idx), 0, "R2 lowest index wins");
        lookup(0, 0, 1, 0, 'h150);
        chk(32'(lkp_hit), 0, "R2 non-leaf never hits");
        lookup(1, 1, 0, 5, 'h100);
        chk(32'(lkp_idx), 6, "R2 second-stage index");
        lookup(0, 1, 1, 6, 'h100);
        chk(32'(lkp_idx), 5, "R2 VM guest6 index");
        lookup(0, 1, 1, 7, 'h100);
        chk(32'(lkp_hit), 0, "R2 unknown guest misses");

        // superpage leaf, R11
        do_fill(3, 0, 1, 0, 0, 1, 0, 'h000, 'h1FF);
        lookup(0, 0, 1, 0, 'h1AB);
        chk(32'(lkp_idx), 3, "R11 superpage lookup index");
        chk(32'(lkp_hit), 1, "R11 superpage lookup hit");
        v = '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 20'd0, 16'd0, 20'h001AB, 8'hF7};
        set_inv(v);
        tick();
        inv_valid = 1'b0;
        chk(32'(valid_vec), 32'hF7, "R11 superpage leaf cleared by inner page");

        // same-cycle interplay, R12
        load_all();
        v = '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 20'd0, 16'd0, 20'h00000, 8'hF0};
        set_inv(v);
        set_fill(1, 0, 1, 0, 0, 2, 0, 'h300, 0);
        lookup(0, 0, 2, 0, 'h100);
        chk(32'(lkp_hit), 1, "R12 lookup sees old contents (hit)");
        chk(32'(lkp_idx), 1, "R12 lookup sees old contents (index)");
        tick();
        inv_valid = 1'b0;
        fill_valid = 1'b0;
        chk(32'(valid_vec), 32'hF2, "R12 fill survives same-cycle clear");
        lookup(0, 0, 2, 0, 'h300);
        chk(32'(lkp_idx), 1, "R12 refilled entry index");
        lookup(0, 0, 2, 0, 'h100);
        chk(32'(lkp_hit), 0, "R12 old mapping gone");

        // reset in the middle of a run, R1
        rst_n = 1'b0;
        tick();
        chk(32'(valid_vec), 0, "R1 reset clears loaded entries");
        rst_n = 1'b1;
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule